// File: doc/BRIEF.md
# User Memory Write Protection Controller

This block sits between a command decoder and a small user memory of 32 words of 16 bits. It takes one request at a time, either a write of up to two consecutive words or a command that permanently locks groups of words. Before anything is stored, it checks the whole request against the word-count limit, the memory bounds, the bank-wide lock status and a set of eight sticky block locks. A rejected request stores nothing and reports an error code. An accepted request runs for a timed program cycle. The cycle is short when every target word is blank (all zero) and long otherwise. The block then issues one memory write strobe per word and pulses `done`.

The memory is modelled as a register array. Word contents and the block locks can be read back through a peek port. Program durations are parameters counted in clock cycles.

Top module: `uwp_ctrl`

## Requirements
- R1: A write of n words at `word_addr` stores `wr_data[15:0]` at that address and, when n is 2, stores `wr_data[31:16]` at the next address. Word addresses 0 to 31 are valid, and `peek_data` returns the word at `peek_addr`.
- R2: A word count above 2 is rejected with `err` = 3 (bad count). Nothing is written and `busy` never rises.
- R3: A word count of 0 behaves exactly like a count of 1.
- R4: When the last target word lies beyond address 31, the request is rejected with `err` = 2 (overrun) and no word is written, not even the words that are in range.
- R5: `bank_lock` is encoded as 0 open, 1 write-locked, 2 permanently write-locked, 3 permanently open and 4 block-lock mode. Codes 5 to 7 count as permanently write-locked. Writes pass under codes 0, 3 and 4, pass under code 1 only while `secured` is high, and are otherwise rejected with `err` = 1 (locked).
- R6: Block b covers words 4b to 4b+3. A write that touches any word in a block whose lock is set is rejected with `err` = 1, and no word of that request is written.
- R7: A lock command (`op_permalock` = 1) ORs `plock_mask` into `block_locks` if `secured` is high, and otherwise fails with `err` = 1. No lock bit is ever cleared.
- R8: `busy` stays high for F+n cycles when every target word (or every selected lock bit, for a lock command) is zero, and for N+n cycles otherwise. F is `FAST_CYC`, N is `NORM_CYC`, and n is 1 for a lock command.
- R9: `done` is a single-cycle pulse in the cycle after `busy` falls. On a rejection, `done` pulses in the cycle after `start` and `busy` never rises. `err` holds its value until the next accepted `start`.
- R10: `start` is ignored while `busy` is high.
- R11: An accepted write raises `mem_we` once per word, in ascending address order, during the last n busy cycles, with `mem_waddr` and `mem_wdata` matching the request. A lock command raises no `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| op_permalock | input | 1 | 1 = block lock command, 0 = word write |
| word_addr | input | 6 | First target word (values above 31 are out of range) |
| word_cnt | input | 4 | Number of words to write (0 means 1) |
| wr_data | input | 32 | Word 0 in the low half, word 1 in the high half |
| bank_lock | input | 3 | Bank lock status code |
| secured | input | 1 | Requester holds secured access |
| plock_mask | input | 8 | Blocks to lock, one bit per block |
| peek_addr | input | 5 | Read-back address |
| peek_data | output | 16 | Stored word at `peek_addr` |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 5 | Write address |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one-cycle pulse) |
| err | output | 2 | 0 none, 1 locked, 2 overrun, 3 bad count |
| block_locks | output | 8 | Sticky block lock bits |

## Verification
The bench builds the block with `NORM_CYC` = 5 and `FAST_CYC` = 2. Because these durations are short and clearly different, every start address from 0 to 35 can be combined with every count from 0 to 3, twice over: the first pass hits blank words and the second hits written ones. The bench measures each `busy` window and checks it against the fast or slow duration.

It also sweeps all eight lock codes with and without `secured`. After blocks are locked, the address sweep is repeated so that every boundary between locked and open blocks gets crossed by two-word writes. The short window also makes a mid-operation `start` easy to place.

// File: rtl/uwp_pkg.sv
// Shared encodings for the user memory write protection controller.
package uwp_pkg;

    // Bank-wide lock status code.
    typedef enum logic [2:0] {
        BK_OPEN       = 3'd0,
        BK_WLOCK      = 3'd1,
        BK_PERM_WLOCK = 3'd2,
        BK_PERM_OPEN  = 3'd3,
        BK_BLOCK_MODE = 3'd4
    } bank_lock_e;

    // Result code of a request.
    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_LOCKED = 2'd1,
        ERR_RANGE  = 2'd2,
        ERR_COUNT  = 2'd3
    } err_e;

    // Sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_COMMIT = 2'd2
    } state_e;

endpackage

// File: rtl/uwp_store.sv
// Word array plus sticky block-lock register.
// Assumes: one write port, NRD combinational read ports, and that WORDS is a
// multiple of BLOCKS with a power-of-two quotient.
module uwp_store #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 16,
    parameter int BLOCKS = 8,
    parameter int NRD    = 3,
    localparam int AW    = $clog2(WORDS),
    localparam int WPB   = WORDS / BLOCKS,
    localparam int BW    = $clog2(WPB)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic                  lock_set,
    input  logic [BLOCKS-1:0]     lock_mask,
    input  logic [NRD*AW-1:0]     rd_addr,
    output logic [NRD*WORD_W-1:0] rd_data,
    output logic [BLOCKS-1:0]     locks
);

    logic [WORD_W-1:0] mem [WORDS];
    logic [AW-BW-1:0]  wblk;

    assign wblk = waddr[AW-1:BW];

    // Word storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Lock bits: set only, never cleared outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        locks <= '0;
        else if (lock_set) locks <= locks | lock_mask;
    end

    // Read ports.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g*WORD_W +: WORD_W] = mem[rd_addr[g*AW +: AW]];
    end

    // R6: a strobe never lands in a locked block.
    p_no_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !locks[wblk]);

    // R7: lock bits are sticky.
    p_locks_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locks != '0) |=> ((locks & $past(locks)) == $past(locks)));

endmodule

// File: rtl/uwp_check.sv
// Combinational admission check: count limit, bounds, bank status, block
// locks, and blank detection for fast timing.
// Assumes: words carries the current contents of addr+k for k < MAX_WORDS.
module uwp_check
    import uwp_pkg::*;
#(
    parameter int WORDS     = 32,
    parameter int WORD_W    = 16,
    parameter int BLOCKS    = 8,
    parameter int MAX_WORDS = 2,
    parameter int CNT_W     = 4,
    localparam int AW       = $clog2(WORDS),
    localparam int RAW      = AW + 1,
    localparam int WPB      = WORDS / BLOCKS,
    localparam int NW       = $clog2(MAX_WORDS + 1)
) (
    input  logic                        is_plock,
    input  logic [RAW-1:0]              addr,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [2:0]                  bank,
    input  logic                        secured,
    input  logic [BLOCKS-1:0]           mask,
    input  logic [BLOCKS-1:0]           locks,
    input  logic [MAX_WORDS*WORD_W-1:0] words,
    output logic [1:0]                  err,
    output logic [NW-1:0]               nwords,
    output logic                        fast
);

    int   n_eff;
    int   idx;
    logic bank_ok;
    logic hit;
    logic blank;

    // Permission of the bank-wide status.
    always_comb begin
        case (bank)
            BK_OPEN, BK_PERM_OPEN, BK_BLOCK_MODE: bank_ok = 1'b1;
            BK_WLOCK:                             bank_ok = secured;
            default:                              bank_ok = 1'b0;
        endcase
    end

    // Per-word lock hit and blank scan over the target words.
    always_comb begin
        n_eff = (cnt == '0) ? 1 : int'(cnt);
        hit   = 1'b0;
        blank = 1'b1;
        idx   = 0;
        for (int k = 0; k < MAX_WORDS; k++) begin
            idx = int'(addr) + k;
            if (k < n_eff && idx < WORDS) begin
                if (locks[idx / WPB]) hit = 1'b1;
                if (words[k*WORD_W +: WORD_W] != '0) blank = 1'b0;
            end
        end
    end

    // Verdict, in priority order.
    always_comb begin
        nwords = NW'(1);
        fast   = blank;
        if (is_plock) begin
            err  = secured ? ERR_NONE : ERR_LOCKED;
            fast = ((locks & mask) == '0);
        end else if (n_eff > MAX_WORDS) begin
            err = ERR_COUNT;
        end else if (int'(addr) + n_eff - 1 > WORDS - 1) begin
            err = ERR_RANGE;
        end else if (!bank_ok || hit) begin
            err = ERR_LOCKED;
        end else begin
            err    = ERR_NONE;
            nwords = NW'(n_eff);
        end
    end

endmodule

// File: rtl/uwp_seq.sv
// Request sequencer: latches an admitted request, waits the selected program
// time, then issues one write strobe per word or one lock update.
// Assumes: NORM_CYC and FAST_CYC are at least 1.
module uwp_seq
    import uwp_pkg::*;
#(
    parameter int WORDS     = 32,
    parameter int WORD_W    = 16,
    parameter int BLOCKS    = 8,
    parameter int MAX_WORDS = 2,
    parameter int NORM_CYC  = 12,
    parameter int FAST_CYC  = 3,
    localparam int AW       = $clog2(WORDS),
    localparam int NW       = $clog2(MAX_WORDS + 1),
    localparam int TMAX     = (NORM_CYC > FAST_CYC) ? NORM_CYC : FAST_CYC,
    localparam int TW       = $clog2(TMAX + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        is_plock,
    input  logic [AW-1:0]               base,
    input  logic [MAX_WORDS*WORD_W-1:0] wdata,
    input  logic [BLOCKS-1:0]           mask,
    input  logic [1:0]                  chk_err,
    input  logic [NW-1:0]               chk_n,
    input  logic                        chk_fast,
    output logic                        busy,
    output logic                        done,
    output logic [1:0]                  err,
    output logic                        we,
    output logic [AW-1:0]               waddr,
    output logic [WORD_W-1:0]           wdata_o,
    output logic                        lock_set,
    output logic [BLOCKS-1:0]           lock_mask
);

    state_e                      state;
    logic [TW-1:0]               timer;
    logic [NW-1:0]               idx;
    logic [NW-1:0]               n_q;
    logic                        plk_q;
    logic [AW-1:0]               base_q;
    logic [MAX_WORDS*WORD_W-1:0] data_q;
    logic [BLOCKS-1:0]           mask_q;
    logic                        last_word;

    assign last_word = (NW'(idx + NW'(1)) == n_q);

    // Request state machine with program timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            timer  <= '0;
            idx    <= '0;
            n_q    <= '0;
            plk_q  <= 1'b0;
            base_q <= '0;
            data_q <= '0;
            mask_q <= '0;
            done   <= 1'b0;
            err    <= ERR_NONE;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        err <= chk_err;
                        if (chk_err != ERR_NONE) begin
                            done <= 1'b1;
                        end else begin
                            state  <= ST_WAIT;
                            timer  <= chk_fast ? TW'(FAST_CYC - 1) : TW'(NORM_CYC - 1);
                            idx    <= '0;
                            n_q    <= chk_n;
                            plk_q  <= is_plock;
                            base_q <= base;
                            data_q <= wdata;
                            mask_q <= mask;
                        end
                    end
                end
                ST_WAIT: begin
                    if (timer == '0) state <= ST_COMMIT;
                    else             timer <= timer - TW'(1);
                end
                ST_COMMIT: begin
                    if (plk_q || last_word) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + NW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode.
    assign busy      = (state != ST_IDLE);
    assign we        = (state == ST_COMMIT) && !plk_q;
    assign waddr     = base_q + AW'(idx);
    assign wdata_o   = data_q[idx*WORD_W +: WORD_W];
    assign lock_set  = (state == ST_COMMIT) && plk_q;
    assign lock_mask = mask_q;

    // R11: strobe index stays inside the admitted count.
    p_idx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && !plk_q) |-> (idx < n_q));

    // R9: an error completion comes straight from idle.
    p_err_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err != ERR_NONE) |-> $past(state == ST_IDLE));

    // R10: latched request is frozen while busy.
    p_hold_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(base_q) && $stable(data_q)));

endmodule

// File: rtl/uwp_ctrl.sv
// Top of the user memory write protection controller: admission check,
// sequencer and storage.
// Assumes: requests arrive as a one-cycle start with stable operands.
module uwp_ctrl #(
    parameter int WORDS     = 32,
    parameter int WORD_W    = 16,
    parameter int BLOCKS    = 8,
    parameter int MAX_WORDS = 2,
    parameter int CNT_W     = 4,
    parameter int NORM_CYC  = 12,
    parameter int FAST_CYC  = 3,
    localparam int AW       = $clog2(WORDS),
    localparam int NRD      = MAX_WORDS + 1,
    localparam int NW       = $clog2(MAX_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        op_permalock,
    input  logic [AW:0]                 word_addr,
    input  logic [CNT_W-1:0]            word_cnt,
    input  logic [MAX_WORDS*WORD_W-1:0] wr_data,
    input  logic [2:0]                  bank_lock,
    input  logic                        secured,
    input  logic [BLOCKS-1:0]           plock_mask,
    input  logic [AW-1:0]               peek_addr,
    output logic [WORD_W-1:0]           peek_data,
    output logic                        mem_we,
    output logic [AW-1:0]               mem_waddr,
    output logic [WORD_W-1:0]           mem_wdata,
    output logic                        busy,
    output logic                        done,
    output logic [1:0]                  err,
    output logic [BLOCKS-1:0]           block_locks
);

    logic [NRD*AW-1:0]     rd_addr;
    logic [NRD*WORD_W-1:0] rd_data;
    logic [1:0]            chk_err;
    logic [NW-1:0]         chk_n;
    logic                  chk_fast;
    logic                  lock_set;
    logic [BLOCKS-1:0]     lock_mask;

    // Read addresses: the target words first, then the peek port.
    for (genvar k = 0; k < MAX_WORDS; k++) begin : g_tgt
        assign rd_addr[k*AW +: AW] = word_addr[AW-1:0] + AW'(k);
    end
    assign rd_addr[MAX_WORDS*AW +: AW] = peek_addr;
    assign peek_data = rd_data[MAX_WORDS*WORD_W +: WORD_W];

    uwp_check #(
        .WORDS(WORDS), .WORD_W(WORD_W), .BLOCKS(BLOCKS),
        .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
    ) u_check (
        .is_plock (op_permalock),
        .addr     (word_addr),
        .cnt      (word_cnt),
        .bank     (bank_lock),
        .secured  (secured),
        .mask     (plock_mask),
        .locks    (block_locks),
        .words    (rd_data[MAX_WORDS*WORD_W-1:0]),
        .err      (chk_err),
        .nwords   (chk_n),
        .fast     (chk_fast)
    );

    uwp_seq #(
        .WORDS(WORDS), .WORD_W(WORD_W), .BLOCKS(BLOCKS),
        .MAX_WORDS(MAX_WORDS), .NORM_CYC(NORM_CYC), .FAST_CYC(FAST_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_plock  (op_permalock),
        .base      (word_addr[AW-1:0]),
        .wdata     (wr_data),
        .mask      (plock_mask),
        .chk_err   (chk_err),
        .chk_n     (chk_n),
        .chk_fast  (chk_fast),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata_o   (mem_wdata),
        .lock_set  (lock_set),
        .lock_mask (lock_mask)
    );

    uwp_store #(
        .WORDS(WORDS), .WORD_W(WORD_W), .BLOCKS(BLOCKS), .NRD(NRD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .lock_set  (lock_set),
        .lock_mask (lock_mask),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .locks     (block_locks)
    );

    // R9: done never overlaps busy.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: strobes only inside a busy window.
    p_we_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

endmodule

// File: tb/uwp_ctrl_bench.sv
// Sweep bench for uwp_ctrl with short program times and a reference model.
module uwp_ctrl_bench;

    localparam int NC = 5;
    localparam int FC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_pl = 1'b0;
    logic [5:0]  word_addr = '0;
    logic [3:0]  word_cnt = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  bank_lock = '0;
    logic        secured = 1'b0;
    logic [7:0]  plock_mask = '0;
    logic [4:0]  peek_addr = '0;
    logic [15:0] peek_data;
    logic        mem_we;
    logic [4:0]  mem_waddr;
    logic [15:0] mem_wdata;
    logic        busy;
    logic        done;
    logic [1:0]  err;
    logic [7:0]  block_locks;

    int total = 0;
    int bad   = 0;

    logic [15:0] mdl [32];
    logic [7:0]  mplk;

    always #4 clk = ~clk;

    uwp_ctrl #(.NORM_CYC(NC), .FAST_CYC(FC)) u_uwp_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_permalock(op_pl),
        .word_addr(word_addr), .word_cnt(word_cnt), .wr_data(wr_data),
        .bank_lock(bank_lock), .secured(secured), .plock_mask(plock_mask),
        .peek_addr(peek_addr), .peek_data(peek_data), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .busy(busy),
        .done(done), .err(err), .block_locks(block_locks)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every stored word with the model through the peek port.
    task automatic mem_cmp(input string req);
        int mism = 0;
        for (int i = 0; i < 32; i++) begin
            peek_addr = 5'(i);
            #1;
            if (peek_data !== mdl[i]) mism++;
        end
        chk(mism == 0, req, mism, 0);
    endtask

    task automatic run_op(input bit pl, input int addr, input int cnt, input int bank,
                          input bit sec, input logic [7:0] mask, input logic [15:0] d0,
                          input logic [15:0] d1, input int poke, input string tag_ovr);
        int n, eerr, dur, expcyc, cyc, wec, guard, expwe;
        bit fast, hit, allowed, weok, pk;
        string tg;
        n = (cnt == 0) ? 1 : cnt;
        dur = n;
        fast = 1'b1;
        hit = 1'b0;
        allowed = (bank == 0 || bank == 3 || bank == 4) || (bank == 1 && sec);
        if (pl) begin
            eerr = sec ? 1 - 1 : 1;
            fast = ((mplk & mask) == 8'h00);
            dur = 1;
            tg = "R7";
        end else if (cnt > 2) begin
            eerr = 3; tg = "R2";
        end else if (addr + n - 1 > 31) begin
            eerr = 2; tg = "R4";
        end else begin
            for (int k = 0; k < n; k++) begin
                if (mplk[(addr + k) / 4]) hit = 1'b1;
                if (mdl[addr + k] != 16'h0) fast = 1'b0;
            end
            eerr = (!allowed || hit) ? 1 : 0;
            tg = !allowed ? "R5" : (hit ? "R6" : (cnt == 0 ? "R3" : "R1"));
        end
        if (tag_ovr != "") tg = tag_ovr;
        expcyc = (eerr != 0) ? 0 : ((fast ? FC : NC) + dur);
        expwe  = (eerr != 0 || pl) ? 0 : n;

        @(negedge clk);
        op_pl = pl; word_addr = 6'(addr); word_cnt = 4'(cnt);
        wr_data = {d1, d0}; bank_lock = 3'(bank); secured = sec;
        plock_mask = mask; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; wec = 0; guard = 0; weok = 1'b1; pk = 1'b0;
        while (!done && guard < 400) begin
            if (busy) cyc++;
            if (mem_we) begin
                if (mem_waddr != 5'(addr + wec)) weok = 1'b0;
                if (mem_wdata != ((wec == 0) ? d0 : d1)) weok = 1'b0;
                wec++;
            end
            if (pk) begin
                start = 1'b0; word_addr = 6'(addr); pk = 1'b0;
            end else if (poke > 0 && cyc == poke) begin
                start = 1'b1; word_addr = 6'd20; pk = 1'b1;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk(guard < 400, "watchdog", guard, 0);
        chk(err == 2'(eerr), tg, int'(err), eerr);
        chk(cyc == expcyc, (eerr != 0) ? "R9" : "R8", cyc, expcyc);
        chk(wec == expwe && weok, "R11", wec, expwe);
        if (eerr == 0) begin
            if (pl) mplk = mplk | mask;
            else begin
                mdl[addr] = d0;
                if (n == 2) mdl[addr + 1] = d1;
            end
        end
        @(negedge clk);
        chk(!done, "R9", int'(done), 0);
        chk(block_locks == mplk, "R7", int'(block_locks), int'(mplk));
        mem_cmp(tg);
    endtask

    // Global watchdog.
    initial begin
        #(8 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d0, d1;
        for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
        mplk = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R9", int'(busy), 0);
        chk(block_locks == 8'h00, "R7", int'(block_locks), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mem_cmp("R1");

        // Address and count sweep, blank pass then overwrite pass.
        for (int pass = 0; pass < 2; pass++)
            for (int a = 0; a < 36; a++)
                for (int c = 0; c < 4; c++) begin
                    d0 = 16'h8000 | 16'(pass * 1024 + a * 16 + c);
                    d1 = d0 ^ 16'h4001;
                    run_op(1'b0, a, c, 0, 1'b0, 8'h00, d0, d1, 0, "");
                end

        // Bank status sweep (R5).
        for (int b = 0; b < 8; b++)
            for (int s = 0; s < 2; s++)
                run_op(1'b0, 8, 1, b, s[0], 8'h00, 16'h9000 | 16'(b * 2 + s), 16'h1,
                       0, "R5");

        // Lock commands (R7).
        run_op(1'b1, 0, 0, 0, 1'b0, 8'h05, 16'h0, 16'h0, 0, "");
        run_op(1'b1, 0, 0, 0, 1'b1, 8'h05, 16'h0, 16'h0, 0, "");
        run_op(1'b1, 0, 0, 0, 1'b1, 8'h02, 16'h0, 16'h0, 0, "");
        run_op(1'b1, 0, 0, 0, 1'b1, 8'h07, 16'h0, 16'h0, 0, "");
        run_op(1'b1, 0, 0, 0, 1'b1, 8'h00, 16'h0, 16'h0, 0, "");

        // Writes against locked blocks 0..2 (R6).
        for (int a = 0; a < 34; a++)
            for (int c = 1; c < 3; c++) begin
                d0 = 16'hC000 | 16'(a * 8 + c);
                d1 = d0 ^ 16'h0F0F;
                run_op(1'b0, a, c, 3, 1'b0, 8'h00, d0, d1, 0, "");
            end

        // Start during busy is ignored (R10).
        run_op(1'b0, 30, 2, 0, 1'b0, 8'h00, 16'hBEEF, 16'hCAFE, 2, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule